// File: doc/BRIEF.md
# SIMD Shift-Right-Narrow Datapath

This block is the execute stage for a family of narrowing right shifts by an immediate on a 128-bit vector register. Every source element, twice the width of the destination element, may first have a rounding constant added. It is then shifted right and either truncated or clamped into a destination element of half its width. The results are merged into the destination register: the lower 64 bits with the upper half cleared, the upper 64 bits with the lower half kept, or a single scalar element with every other bit cleared.

Saturating operations come in three signedness pairs: signed to signed, signed to unsigned, and unsigned to unsigned. Any clamp sets a saturation flag that stays set until reset. The result is registered and appears one cycle after an input pulse, together with an output-valid strobe. Decode and register-file access are done elsewhere.

Top module: `simd_shrn_unit`

## Requirements
- R1: In vector lower form (`scalar_mode`=0, `upper_half`=0), `8>>esz` results (esz 0/1/2 = 8/16/32-bit results from 16/32/64-bit source elements, element i at bits `[i*2e +: 2e]`) go to destination elements 0..n-1, and bits 127:64 are zero.
- R2: In vector upper form (`upper_half`=1), the results go to destination elements n..2n-1, and bits 63:0 equal the old destination bits 63:0.
- R3: In scalar mode, only source element 0 is processed. Its result goes to bits `[e-1:0]` and all other bits are zero, whatever the value of `upper_half`.
- R4: With `round_en`=1, the value `1<<(shamt-1)` is added to the source element before the shift. The shift amount is in the range 1..e.
- R5: With `sat_en`=0, the source element is taken as unsigned, shifted logically and truncated to e bits, whatever the value of `src_signed`. The flag is unaffected.
- R6: Saturating signed-to-signed (`src_signed`=1, `dst_signed`=1) uses an arithmetic shift and clamps to [-2^(e-1), 2^(e-1)-1].
- R7: Saturating signed-to-unsigned (`src_signed`=1, `dst_signed`=0) clamps negative results to 0 and large results to 2^e-1.
- R8: Saturating with `src_signed`=0 clamps to [0, 2^e-1]. In this case `dst_signed` is ignored.
- R9: For 64-bit source elements, the rounding addition keeps the carry out of bit 63.
- R10: `sat_flag` is set when any processed element clamps, and stays set until reset.
- R11: `out_valid` is high exactly one cycle after `in_valid`. `dst_new` changes only in that cycle and holds otherwise.
- R12: During reset, `out_valid`, `dst_new` and `sat_flag` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation strobe |
| src | input | 128 | Source vector |
| dst_old | input | 128 | Current destination vector |
| esz | input | 2 | Result element size code (0/1/2 = 8/16/32 bits) |
| shamt | input | 6 | Right shift amount, 1..e |
| scalar_mode | input | 1 | Process element 0 only |
| upper_half | input | 1 | Write the upper 64 bits and keep the lower 64 bits |
| round_en | input | 1 | Add the rounding constant before the shift |
| sat_en | input | 1 | Clamp instead of truncating |
| src_signed | input | 1 | Source elements are signed (saturating only) |
| dst_signed | input | 1 | Destination range is signed (only with a signed source) |
| out_valid | output | 1 | Result strobe |
| dst_new | output | 128 | New destination vector |
| sat_flag | output | 1 | Sticky saturation flag |

## Verification
The assertions assume that `in_valid` is a single-cycle strobe carrying stable operands, that `esz` is never 3, and that `shamt` lies within 1..e for the selected size. The random stimulus draws the size first and then draws the shift from 1 to that size's result width, so it never leaves this domain. All flag combinations are drawn freely, including the unsigned-source cases where `dst_signed` must have no effect. Directed cases cover the rounding carry on 64-bit elements, negative clamping and the hold behaviour.

// File: rtl/simd_shrn_unit.sv
module simd_shrn_unit (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [127:0] src,
  input  logic [127:0] dst_old,
  input  logic [1:0]   esz,
  input  logic [5:0]   shamt,
  input  logic         scalar_mode,
  input  logic         upper_half,
  input  logic         round_en,
  input  logic         sat_en,
  input  logic         src_signed,
  input  logic         dst_signed,
  output logic         out_valid,
  output logic [127:0] dst_new,
  output logic         sat_flag
);
  localparam int LANES = 8;
  localparam int XW    = 66;

  logic [6:0]    ew;
  logic [6:0]    sw;
  logic          sgn_src;
  logic          sgn_dst;
  logic [XW-1:0] rnd;
  logic [XW-1:0] hi_lim;
  logic [XW-1:0] lo_lim;
  logic [31:0]   emask;

  assign ew      = 7'd8 << esz;
  assign sw      = 7'd16 << esz;
  assign sgn_src = sat_en & src_signed;
  assign sgn_dst = sgn_src & dst_signed;
  assign rnd     = (round_en && shamt != 6'd0) ? (XW'(1) << (shamt - 6'd1)) : '0;
  assign hi_lim  = sgn_dst ? ((XW'(1) << (ew - 7'd1)) - XW'(1)) : ((XW'(1) << ew) - XW'(1));
  assign lo_lim  = sgn_dst ? (XW'(0) - (XW'(1) << (ew - 7'd1))) : '0;
  assign emask   = 32'((33'd1 << ew) - 33'd1);

  logic [31:0]      res [LANES];
  logic [LANES-1:0] lane_sat;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [63:0]   raw;
    logic          msb;
    logic [XW-1:0] ext;
    logic [XW-1:0] sum;
    logic [XW-1:0] shv;
    logic          ov;
    logic          un;

    always_comb begin
      case (esz)
        2'd0:    begin raw = {48'b0, src[16*i +: 16]};     msb = src[16*i+15]; end
        2'd1:    begin raw = {32'b0, src[32*(i%4) +: 32]}; msb = src[32*(i%4)+31]; end
        default: begin raw = src[64*(i%2) +: 64];          msb = src[64*(i%2)+63]; end
      endcase
    end

    assign ext = {2'b00, raw} - ((sgn_src && msb) ? (XW'(1) << sw) : XW'(0));
    assign sum = ext + rnd;
    assign shv = XW'($signed(sum) >>> shamt);
    assign ov  = $signed(shv) > $signed(hi_lim);
    assign un  = $signed(shv) < $signed(lo_lim);

    assign res[i]      = sat_en ? (ov ? hi_lim[31:0] : (un ? lo_lim[31:0] : shv[31:0])) : shv[31:0];
    assign lane_sat[i] = sat_en & (ov | un);
  end

  logic [63:0]      packed_res;
  logic [LANES-1:0] act;

  always_comb begin
    packed_res = '0;
    case (esz)
      2'd0:    for (int i = 0; i < 8; i++) packed_res[8*i +: 8]   = res[i][7:0];
      2'd1:    for (int i = 0; i < 4; i++) packed_res[16*i +: 16] = res[i][15:0];
      default: for (int i = 0; i < 2; i++) packed_res[32*i +: 32] = res[i];
    endcase
  end

  assign act = scalar_mode ? 8'h01 : 8'((9'd1 << (4'd8 >> esz)) - 9'd1);

  logic [127:0] merged;
  always_comb begin
    if (scalar_mode)     merged = {96'b0, res[0] & emask};
    else if (upper_half) merged = {packed_res, dst_old[63:0]};
    else                 merged = {64'b0, packed_res};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      dst_new   <= '0;
      sat_flag  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        dst_new  <= merged;
        sat_flag <= sat_flag | (|(lane_sat & act));
      end
    end
  end
endmodule

module simd_shrn_unit_chk (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic [127:0] dst_old,
  input logic         scalar_mode,
  input logic         upper_half,
  input logic         out_valid,
  input logic [127:0] dst_new,
  input logic         sat_flag
);
  a_r11_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r11_valid_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(dst_new));
  a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    sat_flag |=> sat_flag);
  a_r1_upper_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !scalar_mode && !upper_half) |=> dst_new[127:64] == 64'b0);
  a_r2_lower_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !scalar_mode && upper_half) |=> dst_new[63:0] == $past(dst_old[63:0]));
  a_r3_scalar_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && scalar_mode) |=> dst_new[127:32] == 96'b0);
endmodule

bind simd_shrn_unit simd_shrn_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .dst_old(dst_old),
  .scalar_mode(scalar_mode), .upper_half(upper_half),
  .out_valid(out_valid), .dst_new(dst_new), .sat_flag(sat_flag)
);

// File: tb/simd_shrn_unit_tb_top.sv
module simd_shrn_unit_tb_top;
  logic clk = 0;
  logic rst_n = 0;
  logic in_valid = 0;
  logic [127:0] src = '0, dst_old = '0;
  logic [1:0] esz = 0;
  logic [5:0] shamt = 1;
  logic scalar_mode = 0, upper_half = 0, round_en = 0, sat_en = 0, src_signed = 0, dst_signed = 0;
  logic out_valid, sat_flag;
  logic [127:0] dst_new;

  int checks = 0, errors = 0;
  bit done = 0;
  bit exp_sticky = 0;

  always #4 clk = ~clk;

  simd_shrn_unit dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src(src), .dst_old(dst_old),
    .esz(esz), .shamt(shamt), .scalar_mode(scalar_mode), .upper_half(upper_half),
    .round_en(round_en), .sat_en(sat_en), .src_signed(src_signed), .dst_signed(dst_signed),
    .out_valid(out_valid), .dst_new(dst_new), .sat_flag(sat_flag)
  );

  function automatic logic [127:0] model(input logic [127:0] s, d, input int sz, sh,
                                         input bit sc, up, rn, st, ss, ds, output bit sat);
    int e = 8 << sz;
    int n = sc ? 1 : (8 >> sz);
    int base = (!sc && up) ? n : 0;
    logic [127:0] r;
    logic signed [127:0] v, hi, lo, one;
    bit dse = st && ss && ds;
    one = 128'sd1;
    r = (!sc && up) ? {64'b0, d[63:0]} : '0;
    sat = 0;
    hi = dse ? (one <<< (e - 1)) - one : (one <<< e) - one;
    lo = dse ? -(one <<< (e - 1)) : 128'sd0;
    for (int i = 0; i < n; i++) begin
      v = $signed((s >> (2 * e * i)) & ((128'd1 << (2 * e)) - 128'd1));
      if (st && ss && v[2 * e - 1]) v = v - (one <<< (2 * e));
      if (rn) v = v + (one <<< (sh - 1));
      v = v >>> sh;
      if (st) begin
        if (v > hi) begin v = hi; sat = 1; end
        else if (v < lo) begin v = lo; sat = 1; end
      end
      r = r | ((v & ((128'd1 << e) - 128'd1)) << (e * (base + i)));
    end
    return r;
  endfunction

  task automatic check(input string tag, input logic [127:0] got, exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic op(input string tag, input logic [127:0] s, d, input int sz, sh,
                    input bit sc, up, rn, st, ss, ds);
    logic [127:0] exp;
    bit sat;
    @(negedge clk);
    src = s; dst_old = d; esz = 2'(sz); shamt = 6'(sh);
    scalar_mode = sc; upper_half = up; round_en = rn; sat_en = st;
    src_signed = ss; dst_signed = ds; in_valid = 1;
    exp = model(s, d, sz, sh, sc, up, rn, st, ss, ds, sat);
    exp_sticky = exp_sticky | sat;
    @(negedge clk);
    in_valid = 0;
    check({tag, " data"}, dst_new, exp);
    check({tag, " valid R11"}, {127'b0, out_valid}, 128'd1);
    check({tag, " flag R10"}, {127'b0, sat_flag}, {127'b0, exp_sticky});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [127:0] held;
    repeat (3) @(negedge clk);
    check("R12 reset data", dst_new, '0);
    check("R12 reset valid", {127'b0, out_valid}, '0);
    check("R12 reset flag", {127'b0, sat_flag}, '0);
    rst_n = 1;

    op("R4 round 16to8", 128'h0003, '1, 0, 1, 0, 0, 1, 0, 0, 0);
    check("R4 round value", dst_new, 128'h0002);
    op("R5 truncate unsigned", 128'h1234, '0, 0, 4, 0, 0, 0, 0, 1, 1);
    check("R5 trunc value", dst_new, 128'h23);
    op("R1 lower form", {4{32'hDEADBEEF}}, '1, 1, 8, 0, 0, 0, 0, 0, 0);
    op("R2 upper form", {8{16'h7F00}}, {64'hAAAA, 64'h5555_6666_7777_8888}, 0, 8, 0, 1, 0, 0, 0, 0);
    op("R3 scalar", {64'h1, 64'h0000_0001_2345_6789}, '1, 2, 4, 1, 1, 0, 0, 0, 0);
    check("R10 no clamp yet", {127'b0, sat_flag}, '0);
    op("R6 ss clamp", {8{16'h8000}}, '0, 0, 1, 0, 0, 0, 1, 1, 1);
    check("R6 min value", dst_new, {64'b0, {8{8'h80}}});
    op("R10 stays set", 128'h10, '0, 0, 1, 0, 0, 0, 0, 0, 0);
    op("R7 su negative", {4{32'hFFFF_0000}}, '0, 1, 4, 0, 0, 0, 1, 1, 0);
    check("R7 zero value", dst_new, '0);
    op("R8 uu ignores dst_signed", {2{64'hFFFF_FFFF_0000_0000}}, '0, 2, 1, 0, 0, 0, 1, 0, 1);
    check("R8 max value", dst_new, {64'b0, {2{32'hFFFF_FFFF}}});
    op("R9 carry sat", {64'h0, 64'hFFFF_FFFF_FFFF_FFFF}, '0, 2, 1, 1, 0, 1, 1, 0, 0);
    check("R9 sat value", dst_new, 128'hFFFF_FFFF);
    op("R9 carry trunc", {2{64'hFFFF_FFFF_FFFF_FFFF}}, '0, 2, 1, 0, 0, 1, 0, 0, 0);
    check("R9 trunc value", dst_new, '0);

    held = dst_new;
    @(negedge clk);
    src = '1; dst_old = '1;
    @(negedge clk);
    check("R11 hold data", dst_new, held);
    check("R11 idle valid", {127'b0, out_valid}, '0);

    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    exp_sticky = 0;
    check("R12 flag cleared", {127'b0, sat_flag}, '0);

    void'($urandom(32'd20240917));
    for (int k = 0; k < 400; k++) begin
      int sz = $urandom_range(0, 2);
      int sh = $urandom_range(1, 8 << sz);
      op("R1-random", {$urandom, $urandom, $urandom, $urandom},
         {$urandom, $urandom, $urandom, $urandom}, sz, sh,
         1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule